// File: doc/BRIEF.md
# Two-Wire Strobed Message Receiver

This block is the receive side of a node on a two-wire shared bus. One wire carries serial data. The other wire carries a strobe that only the bus controller drives, at whatever spacing suits it. The block samples both wires with its own clock, passes them through a two-flop synchronizer, and takes one data bit on each rising edge of the strobe. Whichever node places the bits on the data line, the timing always comes from the controller's strobe.

A message has no start bit and no flag pattern. The only thing that marks its start is silence: when no strobe edge arrives for longer than a configured number of clock cycles, the next rising strobe carries the first bit of a new message, and any message still in progress is thrown away. Strobes that arrive after reset but before the first such silence are treated as power-on noise.

Each message carries these fields, most significant bit first:

- the sender's address byte
- the destination address byte
- a control byte whose low nibble gives the number of data bytes
- zero to fifteen data bytes
- a 16-bit CRC

Every node sees every message, but this block acts only on messages whose destination byte equals its own address. For such a message it presents each data byte as it arrives. At the end it gives one completion pulse, which reports either that the CRC matched or that it did not.

Top module: `strobe_bus_rx`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `byte_valid`, `frame_done` and `frame_error` are low.
- R2: A data bit is taken on each rising edge of the synchronized strobe. Any spacing between strobe edges of fewer than `GAP_MAX` clock cycles is accepted, and the spacing may vary from bit to bit.
- R3: A period of `GAP_MAX` or more cycles with no strobe edge makes the next rising strobe the first bit of a new message. A message cut short by such a period produces no `frame_done` and no `frame_error`.
- R4: Strobes received after reset and before the first silence period produce no output at all.
- R5: Bytes are sent most significant bit first, in this order:
  - byte 0: the sender's address
  - byte 1: the destination address
  - byte 2: control, where bits 3:0 give N, the number of data bytes (0 to 15)
  - N data bytes
  - the CRC, high byte first, then low byte
- R6: A message whose destination byte differs from `node_addr` produces no `byte_valid`, no `frame_done` and no `frame_error`.
- R7: For an accepted message, each data byte appears on `byte_data` with a one-cycle `byte_valid`, in the order the bytes were sent.
- R8: The CRC uses polynomial 0x1021 with a starting value of 0xFFFF. It is computed MSB first over every bit before the CRC field. When the received CRC matches, `frame_done` pulses for one cycle.
- R9: When the received CRC does not match, `frame_error` pulses for one cycle and `frame_done` stays low. The two flags are never high together.
- R10: After a message completes, further strobes are ignored until the next silence period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, used to oversample both wires |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_data | input | 1 | Serial data wire, asynchronous to `clk` |
| bus_strobe | input | 1 | Strobe wire from the bus controller, asynchronous to `clk` |
| node_addr | input | 8 | This node's address, compared with the destination byte |
| byte_data | output | 8 | Received data byte |
| byte_valid | output | 1 | One-cycle pulse: `byte_data` holds a new data byte |
| frame_done | output | 1 | One-cycle pulse: an accepted message ended with a good CRC |
| frame_error | output | 1 | One-cycle pulse: an accepted message ended with a bad CRC |

## Verification
The cases that are hardest to reach from the ports are the ones that depend on where silence falls: strobes that arrive before the receiver has ever seen silence, and a message cut off in its header. The bench covers the first by starting a complete, correctly addressed message within a few cycles of reset release and checking that nothing comes out. It covers the second by stopping a message after twenty bits, holding the strobe quiet past the limit, and then requiring that only the following message is reported. A further case sends a second message straight after the first with no silence between them, and checks that the receiver ignores it.

// File: rtl/strobe_bus_rx.sv
`timescale 1ns/1ps
module strobe_bus_rx #(
  parameter int GAP_MAX = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_data,
  input  logic       bus_strobe,
  input  logic [7:0] node_addr,
  output logic [7:0] byte_data,
  output logic       byte_valid,
  output logic       frame_done,
  output logic       frame_error
);
  localparam int CW = $clog2(GAP_MAX + 1);
  localparam logic [CW-1:0] GAP_LAST = CW'(GAP_MAX - 1);
  localparam logic [CW-1:0] GAP_SAT  = CW'(GAP_MAX);

  typedef enum logic [1:0] {S_WAIT, S_ARM, S_RECV} st_t;

  logic          d_s1, d_s2, s_s1, s_s2, s_prev;
  logic [CW-1:0] gap_cnt;
  st_t           state;
  logic [6:0]    shreg;
  logic [2:0]    bit_cnt;
  logic [4:0]    byte_idx;
  logic [3:0]    len;
  logic [15:0]   crc;
  logic [7:0]    crc_hi;
  logic          match;

  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic b);
    crc_step = {c[14:0], 1'b0} ^ ((c[15] ^ b) ? 16'h1021 : 16'h0000);
  endfunction

  wire       edge_any = s_s2 ^ s_prev;
  wire       rise     = s_s2 & ~s_prev;
  wire       timeout  = !edge_any && (gap_cnt == GAP_LAST);
  wire [7:0] nbyte    = {shreg, d_s2};
  wire [4:0] body_end = 5'd3 + 5'(len);
  wire       in_body  = (byte_idx < 5'd3) || (byte_idx < body_end);
  wire       last_bit = (bit_cnt == 3'd7);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d_s1 <= 1'b0; d_s2 <= 1'b0;
      s_s1 <= 1'b0; s_s2 <= 1'b0; s_prev <= 1'b0;
    end else begin
      d_s1 <= bus_data;   d_s2 <= d_s1;
      s_s1 <= bus_strobe; s_s2 <= s_s1; s_prev <= s_s2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                gap_cnt <= '0;
    else if (edge_any)         gap_cnt <= '0;
    else if (gap_cnt != GAP_SAT) gap_cnt <= gap_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_WAIT;
      shreg       <= '0;
      bit_cnt     <= '0;
      byte_idx    <= '0;
      len         <= '0;
      crc         <= 16'hFFFF;
      crc_hi      <= '0;
      match       <= 1'b0;
      byte_data   <= '0;
      byte_valid  <= 1'b0;
      frame_done  <= 1'b0;
      frame_error <= 1'b0;
    end else begin
      byte_valid  <= 1'b0;
      frame_done  <= 1'b0;
      frame_error <= 1'b0;
      if (timeout) begin
        state <= S_ARM;
      end else if (rise) begin
        case (state)
          S_ARM: begin
            state    <= S_RECV;
            shreg    <= {6'b0, d_s2};
            bit_cnt  <= 3'd1;
            byte_idx <= '0;
            len      <= '0;
            match    <= 1'b0;
            crc      <= crc_step(16'hFFFF, d_s2);
          end
          S_RECV: begin
            if (in_body) crc <= crc_step(crc, d_s2);
            shreg   <= nbyte[6:0];
            bit_cnt <= bit_cnt + 1'b1;
            if (last_bit) begin
              byte_idx <= byte_idx + 1'b1;
              if (byte_idx == 5'd1) begin
                match <= (nbyte == node_addr);
              end else if (byte_idx == 5'd2) begin
                len <= nbyte[3:0];
              end else if (in_body) begin
                if (match) begin
                  byte_data  <= nbyte;
                  byte_valid <= 1'b1;
                end
              end else if (byte_idx == body_end) begin
                crc_hi <= nbyte;
              end else begin
                state <= S_WAIT;
                if (match) begin
                  if ({crc_hi, nbyte} == crc) frame_done  <= 1'b1;
                  else                        frame_error <= 1'b1;
                end
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assert_flags_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(frame_done && frame_error));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);

  assert_error_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_error |=> !frame_error);

  assert_only_matched_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid || frame_done || frame_error) |-> match);

  assert_byte_in_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |-> (state == S_RECV));

  assert_start_after_silence_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == S_RECV) && ($past(state) != S_RECV)) |-> ($past(state) == S_ARM));

  assert_end_leaves_frame_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done || frame_error) |-> (state == S_WAIT));

endmodule

// File: tb/strobe_bus_rx_tb.sv
`timescale 1ns/1ps
module strobe_bus_rx_tb;
  localparam int GAP = 64;
  localparam logic [7:0] NODE = 8'h3C;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_data = 1'b0;
  logic       bus_strobe = 1'b0;
  logic [7:0] byte_data;
  logic       byte_valid, frame_done, frame_error;

  strobe_bus_rx #(.GAP_MAX(GAP)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_data(bus_data), .bus_strobe(bus_strobe),
    .node_addr(NODE), .byte_data(byte_data), .byte_valid(byte_valid),
    .frame_done(frame_done), .frame_error(frame_error)
  );

  always #5 clk = ~clk;

  int checks = 0, fails = 0;
  int nbytes = 0, ndone = 0, nerr = 0;
  logic [7:0] got [0:31];
  logic [7:0] fb  [0:20];
  logic [7:0] exp_data [0:15];
  bit finished = 0;

  always @(negedge clk) if (rst_n) begin
    if (byte_valid) begin
      if (nbytes < 32) got[nbytes] = byte_data;
      nbytes++;
    end
    if (frame_done)  ndone++;
    if (frame_error) nerr++;
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] crc_calc(input int n);
    logic [15:0] c = 16'hFFFF;
    for (int i = 0; i < n; i++)
      for (int b = 7; b >= 0; b--)
        c = {c[14:0], 1'b0} ^ ((c[15] ^ fb[i][b]) ? 16'h1021 : 16'h0000);
    return c;
  endfunction

  task automatic clear_mon();
    @(posedge clk);
    nbytes = 0; ndone = 0; nerr = 0;
  endtask

  task automatic silence();
    bus_strobe = 1'b0;
    repeat (GAP + 30) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] rx, input int len, input bit bad,
                            input int seed, input int limit);
    logic [15:0] c;
    int total;
    fb[0] = 8'hA1;
    fb[1] = rx;
    fb[2] = {4'h5, 4'(len)};
    for (int i = 0; i < len; i++) begin
      fb[3+i] = 8'(seed * 13 + i * 29 + 7);
      exp_data[i] = fb[3+i];
    end
    c = crc_calc(3 + len);
    if (bad) c = c ^ 16'h0100;
    fb[3+len] = c[15:8];
    fb[4+len] = c[7:0];
    total = (5 + len) * 8;
    if (limit >= 0 && limit < total) total = limit;
    for (int k = 0; k < total; k++) begin
      @(negedge clk);
      bus_data = fb[k/8][7 - (k%8)];
      repeat (3 + ((k * 7 + seed) % 9)) @(negedge clk);
      bus_strobe = 1'b1;
      repeat (2 + ((k * 5 + seed) % 7)) @(negedge clk);
      bus_strobe = 1'b0;
    end
    repeat (10) @(negedge clk);
  endtask

  task automatic check_frame(input string req, input int eb, input int ed, input int ee);
    chk(req, "byte count", nbytes, eb);
    chk(req, "done count", ndone, ed);
    chk(req, "error count", nerr, ee);
    for (int i = 0; i < eb && i < nbytes; i++)
      chk(req, $sformatf("data byte %0d", i), int'(got[i]), int'(exp_data[i]));
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R1", "outputs in reset", {byte_valid, frame_done, frame_error}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "outputs after reset", {byte_valid, frame_done, frame_error}, 0);
  endtask

  task automatic t_glitch_before_silence();
    clear_mon();
    send_frame(NODE, 2, 0, 1, -1);
    check_frame("R4", 0, 0, 0);
    silence();
  endtask

  task automatic t_good();
    clear_mon();
    send_frame(NODE, 3, 0, 2, -1);
    check_frame("R8", 3, 1, 0);
    silence();
  endtask

  task automatic t_other_addr();
    clear_mon();
    send_frame(NODE ^ 8'h01, 4, 0, 3, -1);
    check_frame("R6", 0, 0, 0);
    silence();
  endtask

  task automatic t_bad_crc();
    clear_mon();
    send_frame(NODE, 2, 1, 4, -1);
    check_frame("R9", 2, 0, 1);
    silence();
  endtask

  task automatic t_empty();
    clear_mon();
    send_frame(NODE, 0, 0, 5, -1);
    check_frame("R5", 0, 1, 0);
    silence();
  endtask

  task automatic t_long_irregular();
    clear_mon();
    send_frame(NODE, 15, 0, 6, -1);
    check_frame("R2", 15, 1, 0);
    chk("R7", "bytes in order", nbytes, 15);
    silence();
  endtask

  task automatic t_truncated();
    clear_mon();
    send_frame(NODE, 3, 0, 7, 20);
    silence();
    chk("R3", "no flags from cut message", ndone + nerr, 0);
    send_frame(NODE, 1, 0, 8, -1);
    check_frame("R3", 1, 1, 0);
    silence();
  endtask

  task automatic t_back_to_back();
    clear_mon();
    send_frame(NODE, 2, 0, 9, -1);
    check_frame("R10", 2, 1, 0);
    send_frame(NODE, 3, 0, 10, -1);
    chk("R10", "bytes after second message", nbytes, 2);
    chk("R10", "done after second message", ndone, 1);
    silence();
  endtask

  initial begin
    #1_500_000;
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_glitch_before_silence();
    t_good();
    t_other_addr();
    t_bad_crc();
    t_empty();
    t_long_irregular();
    t_truncated();
    t_back_to_back();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule